// File: doc/BRIEF.md
# Double-Latched Volume Control Bank

This block keeps the attenuation settings for eight audio channels, arranged as four left/right pairs. A host writes settings through a plain write port: a 5-bit address and a 9-bit data word, accepted in any cycle where the write enable is high. Each channel has two registers. The staging register (pre-latch) takes new codes. The active register drives the gain stage downstream. New codes can be staged on several channels and then made live together by one write that carries the update flag. A master address loads the same code into every staging register in one write.

Once an update is requested, every channel holds a pending transfer. With zero-cross gating disabled, the transfer lands on the next sample strobe. With gating enabled, it waits for a strobe whose sample is near silence, so the gain step does not cause a click. A shared timeout forces any transfer still pending once a fixed number of clocks has passed. A control bit turns the timeout off. The block's outputs are the eight active 7-bit codes. The gain stage itself, the serial host link and the mapping from codes to decibels are all outside this block.

Top module: `volBank`

## Requirements
- R1: After reset, every active code and every staging register holds 7'h7F, which means 0 dB. All zero-cross enables are 0 and the timeout-disable bit is 0.
- R2: Addresses 0 to 7 select the channels L1, R1, L2, R2, L3, R3, L4 and R4, in that order. `activeCodes[7*i +: 7]` is the active code of the channel at address i. Write data bits [6:0] hold the code, bit 7 holds that channel's zero-cross enable, and bit 8 is the update request.
- R3: A write to a channel address or to the master address with bit 8 clear changes only staging state. No active code changes because of it.
- R4: A write to addresses 0 to 8 with bit 8 set stores its own data first and then marks every channel pending. A pending channel with its zero-cross enable at 0 copies its staging code into its active code at the first sample strobe in a later cycle. The new code is visible from the cycle after that strobe.
- R5: A write to address 8 (master) loads data[6:0] into all eight staging registers and data[7] into all eight zero-cross enables.
- R6: A pending channel with its zero-cross enable at 1 transfers only at a strobe where one of two conditions holds. Either the sign of its sample differs from the sign of its previous strobed sample (that previous sign is "positive" after reset), or the sample's magnitude is below 4.
- R7: If transfers are still pending TIMEOUT_CYCLES clocks after the edge that accepted the update write, every pending channel is transferred at that edge. A new update write restarts the count, and a transfer always uses the staging contents at the moment it happens.
- R8: Bit 3 of a write to address 5'h13 sets the timeout-disable bit. While that bit is 1, no timeout transfer occurs. If the bit is cleared after the timeout has already elapsed, the pending transfer happens one cycle later.
- R9: Writes to address 9 to 5'h12 or 5'h14 to 5'h1F change nothing: no staging register and no enable changes, and they make no update request.
- R10: An active code changes only at an edge whose cycle had the sample strobe high or a timeout transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control port |
| wrAddr | input | 5 | Register address |
| wrData | input | 9 | Write data: code, zero-cross enable, update |
| sampleStrobe | input | 1 | High for one cycle when new samples are valid |
| samples | input | 8*SAMPLE_W | Signed sample per channel, channel i at [SAMPLE_W*i +: SAMPLE_W] |
| activeCodes | output | 56 | Active attenuation code per channel, channel i at [7*i +: 7] |

## Verification
The checker watches four things on every cycle:
- an active code never moves without a strobe or a timeout transfer;
- an update request always leaves transfers pending;
- a fresh update request never meets a timeout transfer in the next cycle;
- the disable bit fully blocks timeout transfers.

Some behaviour can only be shown by the bench's scenarios: the address map, the master overwrite, the sign-change and small-magnitude conditions for zero crossing, the exact timeout edge and its restart, and the fact that undefined addresses are ignored. The bench shows these with directed sequences and with a cycle-level model that it runs against randomised writes, strobes and samples.

// File: rtl/volPkg.sv
package volPkg;
  localparam int NUM_CH      = 8;
  localparam int CODE_W      = 7;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 9;
  localparam int MASTER_ADDR = 8;
  localparam int TOD_ADDR    = 19;
  localparam int TOD_BIT     = 3;
  localparam int ZC_BIT      = 7;
  localparam int UPD_BIT     = 8;

  typedef struct packed {
    logic [NUM_CH-1:0] preLoad;    // per-channel staging load
    logic [CODE_W-1:0] code;       // code to stage
    logic              zcBit;      // zero-cross enable to stage
    logic              arm;        // update request: mark all pending
    logic              forceApply; // timeout transfer
  } volStrobes_t;
endpackage

// File: rtl/volCtrl.sv
module volCtrl
  import volPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 131072
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              anyPending,
  output volStrobes_t       strobes,
  output logic              todOn
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] waitCnt;
  logic masterHit, armReq, todHit, timedOut;

  assign masterHit = wrEn && (wrAddr == ADDR_W'(MASTER_ADDR));
  assign todHit    = wrEn && (wrAddr == ADDR_W'(TOD_ADDR));
  assign armReq    = wrEn && (wrAddr <= ADDR_W'(MASTER_ADDR)) && wrData[UPD_BIT];
  assign timedOut  = anyPending && (waitCnt == LAST) && !todOn && !armReq;

  for (genvar i = 0; i < NUM_CH; i++) begin : gDecode
    assign strobes.preLoad[i] = masterHit || (wrEn && (wrAddr == ADDR_W'(i)));
  end

  assign strobes.code       = wrData[CODE_W-1:0];
  assign strobes.zcBit      = wrData[ZC_BIT];
  assign strobes.arm        = armReq;
  assign strobes.forceApply = timedOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      todOn <= 1'b0;
    end else if (todHit) begin
      todOn <= wrData[TOD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (armReq) begin
      waitCnt <= '0;
    end else if (anyPending && (waitCnt != LAST)) begin
      waitCnt <= waitCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/volZeroDet.sv
module volZeroDet #(
  parameter int SAMPLE_W  = 16,
  parameter int ZC_THRESH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStrobe,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                crossing
);
  localparam int MAG_W = SAMPLE_W + 1;

  logic             prevNeg;
  logic [MAG_W-1:0] extended, magnitude;

  assign extended  = {sample[SAMPLE_W-1], sample};
  assign magnitude = sample[SAMPLE_W-1] ? (~extended + MAG_W'(1)) : extended;
  assign crossing  = (sample[SAMPLE_W-1] != prevNeg) || (magnitude < MAG_W'(ZC_THRESH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevNeg <= 1'b0;
    end else if (sampleStrobe) begin
      prevNeg <= sample[SAMPLE_W-1];
    end
  end
endmodule

// File: rtl/volDatapath.sv
module volDatapath
  import volPkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int ZC_THRESH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  volStrobes_t                strobes,
  input  logic                       sampleStrobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic [NUM_CH*CODE_W-1:0]   activeCodes,
  output logic                       anyPending
);
  logic [NUM_CH-1:0] pendingVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [CODE_W-1:0] preLatch, active;
    logic zcEn, pending, crossing, applyNow;

    volZeroDet #(.SAMPLE_W(SAMPLE_W), .ZC_THRESH(ZC_THRESH)) uDet (
      .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
      .sample(samples[ch*SAMPLE_W +: SAMPLE_W]), .crossing(crossing)
    );

    assign applyNow = pending &&
                      ((sampleStrobe && (!zcEn || crossing)) || strobes.forceApply);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preLatch <= '1;
        zcEn     <= 1'b0;
        active   <= '1;
        pending  <= 1'b0;
      end else begin
        if (applyNow) active <= preLatch;
        if (strobes.arm)   pending <= 1'b1;
        else if (applyNow) pending <= 1'b0;
        if (strobes.preLoad[ch]) begin
          preLatch <= strobes.code;
          zcEn     <= strobes.zcBit;
        end
      end
    end

    assign activeCodes[ch*CODE_W +: CODE_W] = active;
    assign pendingVec[ch] = pending;
  end

  assign anyPending = |pendingVec;
endmodule

// File: rtl/volBank.sv
module volBank
  import volPkg::*;
#(
  parameter int SAMPLE_W       = 16,
  parameter int ZC_THRESH      = 4,
  parameter int TIMEOUT_CYCLES = 131072
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       sampleStrobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic [NUM_CH*CODE_W-1:0]   activeCodes
);
  volStrobes_t strobes;
  logic anyPending, todOn;

  volCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .anyPending(anyPending), .strobes(strobes), .todOn(todOn)
  );

  volDatapath #(.SAMPLE_W(SAMPLE_W), .ZC_THRESH(ZC_THRESH)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleStrobe(sampleStrobe),
    .samples(samples), .activeCodes(activeCodes), .anyPending(anyPending)
  );
endmodule

// File: rtl/volBankChecker.sv
module volBankChecker #(
  parameter int CODES_W = 56
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleStrobe,
  input logic [CODES_W-1:0] activeCodes,
  input logic               arm,
  input logic               forceApply,
  input logic               anyPending,
  input logic               todOn
);
  a_r1_reset_codes: assert property (@(posedge clk) !rstN |=> (activeCodes == '1))
    else $error("R1: active codes not at 0 dB after reset");

  a_r4_arm_pending: assert property (@(posedge clk) disable iff (!rstN) arm |=> anyPending)
    else $error("R4: update request left nothing pending");

  a_r7_arm_restarts: assert property (@(posedge clk) disable iff (!rstN) arm |=> !forceApply)
    else $error("R7: timeout fired right after a restart");

  a_r8_tod_blocks: assert property (@(posedge clk) disable iff (!rstN) todOn |-> !forceApply)
    else $error("R8: timeout transfer while disabled");

  a_r10_change_cause: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(activeCodes) |-> ($past(sampleStrobe) || $past(forceApply)))
    else $error("R10: active code moved without strobe or timeout");
endmodule

bind volBank volBankChecker #(.CODES_W(volPkg::NUM_CH * volPkg::CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .activeCodes(activeCodes),
  .arm(strobes.arm), .forceApply(strobes.forceApply), .anyPending(anyPending),
  .todOn(todOn)
);

// File: tb/volBank_test.sv
module volBank_test;
  localparam int SW  = 16;
  localparam int TO  = 256;
  localparam int NCH = 8;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, sampleStrobe = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [8:0] wrData = '0;
  logic [NCH*SW-1:0] samples = '0;
  logic [NCH*7-1:0] activeCodes;

  always #5 clk = ~clk;

  volBank #(.SAMPLE_W(SW), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleStrobe(sampleStrobe), .samples(samples), .activeCodes(activeCodes)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [6:0] mPre[NCH], mAct[NCH];
  bit mZc[NCH], mPend[NCH], mPrev[NCH];
  bit mTod;
  int mCnt;

  function automatic logic [6:0] outCode(int ch);
    return activeCodes[ch*7 +: 7];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mPre[c] = 7'h7F; mAct[c] = 7'h7F; mZc[c] = 0; mPend[c] = 0; mPrev[c] = 0;
    end
    mTod = 0; mCnt = 0;
  endtask

  // one clock: model next state from driven inputs, commit at edge, compare at negedge
  task automatic cyc();
    logic [6:0] nPre[NCH], nAct[NCH];
    bit nZc[NCH], nPend[NCH], nPrev[NCH];
    bit anyP, arm, force_, nTod;
    int nCnt;
    anyP = 0;
    for (int c = 0; c < NCH; c++) anyP |= mPend[c];
    arm = wrEn && (wrAddr <= 5'd8) && wrData[8];
    force_ = anyP && (mCnt == TO - 1) && !mTod && !arm;
    for (int c = 0; c < NCH; c++) begin
      logic signed [SW-1:0] s;
      int mag;
      bit zx, ap;
      s = samples[c*SW +: SW];
      mag = (s < 0) ? -int'(s) : int'(s);
      zx = ((s < 0) != mPrev[c]) || (mag < 4);
      ap = mPend[c] && ((sampleStrobe && (!mZc[c] || zx)) || force_);
      nAct[c] = ap ? mPre[c] : mAct[c];
      nPend[c] = arm ? 1'b1 : (ap ? 1'b0 : mPend[c]);
      nPrev[c] = sampleStrobe ? (s < 0) : mPrev[c];
      nPre[c] = mPre[c]; nZc[c] = mZc[c];
      if (wrEn && (wrAddr == 5'(c) || wrAddr == 5'd8)) begin
        nPre[c] = wrData[6:0]; nZc[c] = wrData[7];
      end
    end
    nTod = (wrEn && wrAddr == 5'd19) ? wrData[3] : mTod;
    nCnt = arm ? 0 : ((anyP && mCnt != TO - 1) ? mCnt + 1 : mCnt);
    @(posedge clk);
    mPre = nPre; mAct = nAct; mZc = nZc; mPend = nPend; mPrev = nPrev;
    mTod = nTod; mCnt = nCnt;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) chk("model R2/R4", outCode(c), mAct[c]);
  endtask

  task automatic wr(int addr, logic [8:0] data);
    wrEn = 1; wrAddr = 5'(addr); wrData = data;
    cyc();
    wrEn = 0;
  endtask

  task automatic strobe(int value);
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'(value);
    sampleStrobe = 1;
    cyc();
    sampleStrobe = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int c = 0; c < NCH; c++) chk("R1 reset code", outCode(c), 7'h7F);

    wr(6, {2'b00, 7'h20});
    strobe(1000);
    chk("R3 staged only", outCode(6), 7'h7F);

    wr(7, {2'b10, 7'h11});
    cyc(); cyc();
    chk("R10 no strobe no change", outCode(7), 7'h7F);
    strobe(1000);
    chk("R4 L4 applied", outCode(6), 7'h20);
    chk("R4 R4 applied", outCode(7), 7'h11);
    chk("R2 L1 untouched", outCode(0), 7'h7F);

    wr(9, {2'b10, 7'h33});
    wr(31, {2'b10, 7'h55});
    wr(18, {2'b10, 7'h56});
    strobe(1000);
    chk("R9 undefined addr no arm", outCode(6), 7'h20);
    wr(0, {2'b10, 7'h7F});
    strobe(1000);
    chk("R9 undefined addr no stage", outCode(6), 7'h20);
    chk("R9 undefined addr no stage", outCode(1), 7'h7F);

    wr(8, {2'b00, 7'h05});
    strobe(1000);
    chk("R3 master staged only", outCode(3), 7'h7F);
    wr(3, {2'b10, 7'h0A});
    strobe(1000);
    chk("R5 master L1", outCode(0), 7'h05);
    chk("R5 master R4", outCode(7), 7'h05);
    chk("R5 later write wins", outCode(3), 7'h0A);

    wr(8, {2'b11, 7'h40});
    strobe(1000);
    chk("R6 no crossing holds", outCode(0), 7'h05);
    strobe(-1000);
    chk("R6 sign change applies", outCode(0), 7'h40);
    wr(8, {2'b11, 7'h41});
    strobe(-4);
    chk("R6 magnitude 4 holds", outCode(5), 7'h40);
    strobe(-3);
    chk("R6 magnitude 3 applies", outCode(5), 7'h41);

    wr(8, {2'b11, 7'h50});
    repeat (TO - 1) cyc();
    chk("R7 before timeout", outCode(0), 7'h41);
    cyc();
    chk("R7 at timeout", outCode(0), 7'h50);
    wr(8, {2'b11, 7'h51});
    repeat (TO / 2) cyc();
    wr(8, {2'b11, 7'h52});
    repeat (TO - 1) cyc();
    chk("R7 restart holds", outCode(4), 7'h50);
    cyc();
    chk("R7 restart newest", outCode(4), 7'h52);

    wr(19, 9'h008);
    wr(8, {2'b11, 7'h60});
    repeat (2 * TO) cyc();
    chk("R8 timeout disabled", outCode(2), 7'h52);
    wr(19, 9'h000);
    chk("R8 clear still holds", outCode(2), 7'h52);
    cyc();
    chk("R8 late timeout applies", outCode(2), 7'h60);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 12);
      wrEn = ($urandom % 6) == 0;
      wrAddr = (r < 9) ? 5'(r) : ((r == 9) ? 5'd19 : 5'($urandom));
      wrData = 9'($urandom);
      sampleStrobe = ($urandom % 4) == 0;
      for (int c = 0; c < NCH; c++)
        samples[c*SW +: SW] = (($urandom % 3) == 0) ? SW'(int'($urandom % 9) - 4) : SW'($urandom);
      cyc();
    end
    wrEn = 0; sampleStrobe = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule